// File: doc/BRIEF.md
# Guarded Byte Store Controller

This block is a register-mapped controller for a small byte-wide storage array that plays the part of on-chip nonvolatile data memory. A processor reaches it through four byte registers: a cell pointer, a data buffer, a control/status register and a write-only key register. Reads of a cell finish in one cycle. A store into a cell is deliberately hard to start: software has to present a two-byte key and then request the store while the store permission bit is already set. Each accepted store then occupies the array for a fixed, parameterised number of clocks, after which a sticky completion flag is raised and may be routed to an interrupt.

The register port is a single-beat request channel. `bus_valid` qualifies one access per cycle. The block never applies back-pressure, so every request is taken in the cycle it is presented. Bus reads are combinational: `bus_rdata` always shows the register selected by `bus_addr`. Register offsets: 0 = cell pointer, 1 = data buffer, 2 = control, 3 = key. Control bit meanings: bit0 = read request (self-clearing, reads 0), bit1 = store request / store busy, bit2 = store permission, bit3 = alternate space select A, bit4 = alternate space select B, bit5 = completion flag. Bits 7:6 read 0.

Top module: `nvm_data_ctrl`

## Requirements
- R1: After reset the pointer, data buffer and control register read 0x00, `irq` and `wr_busy` are 0, and every cell of the array holds 0xFF.
- R2: A control write with bit0 = 1 and bits 3 and 4 both 0 loads the data buffer with the cell named by the pointer, visible from the next cycle. Bit0 always reads back 0.
- R3: A read request whose control write has bit3 or bit4 set is ignored, and the data buffer keeps its value.
- R4: The data buffer keeps its value until a valid read or a software write to offset 1.
- R5: A store starts only on a control write with bit1 = 1 and bits 3 and 4 both 0, when the two previous bus writes were 0x55 to the key register and then 0xAA to the key register. Any other bus write in between resets the key sequence. A write of 0x55 to the key register always restarts it. Bus reads do not disturb it.
- R6: The store request is ignored unless the permission bit was already 1 before the control write. Setting both bits in the same write does not start a store.
- R7: A started store holds control bit1 and `wr_busy` at 1 for exactly WR_CYCLES cycles. It then writes the array cell.
- R8: The store uses the pointer and data values captured at its start. Clearing the permission bit, or rewriting the pointer or data buffer, during the store does not change what is written or when.
- R9: When a store finishes, the completion flag (bit5) is set. It stays set until a control write carries bit5 = 0. A control write with bit5 = 1 never sets it.
- R10: Only control writes change the permission bit. Hardware never clears it.
- R11: While a store is in progress, read requests and new store requests are ignored.
- R12: `irq` equals the completion flag ANDed with `irq_en`.
- R13: Each byte needs a fresh key sequence. A store request after a completed store, with no new key sequence, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request, accepted in its cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Selected register contents (combinational) |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| wr_busy | output | 1 | Store in progress |
| irq | output | 1 | Completion interrupt |

## Verification
The checker watches on every cycle that a store begins only after an armed key sequence with permission already set, that the busy window lasts exactly WR_CYCLES cycles, and that completion is raised only when busy falls. It also checks that the permission bit moves only on control writes, that a read request during a store leaves the data buffer alone, and that the interrupt never fires without its enable. Whether the right byte lands in the right cell, whether deviating key orders are rejected, and whether mid-store pointer or data rewrites stay harmless can only be shown by the bench. The bench runs those scenarios against its cycle-by-cycle reference model.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] OFS_PTR  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_KEY  = 2'd3;

  localparam int unsigned B_RD   = 0;
  localparam int unsigned B_WR   = 1;
  localparam int unsigned B_WEN  = 2;
  localparam int unsigned B_SELA = 3;
  localparam int unsigned B_SELB = 4;
  localparam int unsigned B_DONE = 5;

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_ONE  = 2'd1,
    KS_TWO  = 2'd2
  } key_state_e;
endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm
  import nvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [1:0]        wr_ofs,
  input  logic [BYTE_W-1:0] wr_val,
  output logic              armed
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_strobe) begin
      if (wr_ofs != OFS_KEY)            state_d = KS_IDLE;
      else if (wr_val == KEY_FIRST)     state_d = KS_ONE;
      else if (wr_val == KEY_SECOND && state_q == KS_ONE) state_d = KS_TWO;
      else                              state_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == KS_TWO);
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer
  import nvm_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 64,
  parameter int unsigned AW        = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [BYTE_W-1:0] start_data,
  output logic              busy,
  output logic              commit,
  output logic [AW-1:0]     commit_addr,
  output logic [BYTE_W-1:0] commit_data
);
  localparam int unsigned CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

  logic [CW-1:0]     left_q;
  logic              busy_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      left_q <= LOAD;
      addr_q <= start_addr;
      data_q <= start_data;
    end
  end

  assign busy        = busy_q;
  assign commit      = busy_q && (left_q == '0);
  assign commit_addr = addr_q;
  assign commit_data = data_q;
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array
  import nvm_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] cell_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                          cell_q[i] <= '1;
      else if (we && waddr == AW'(i))      cell_q[i] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/nvm_data_ctrl.sv
module nvm_data_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned WR_CYCLES = 64
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       bus_write,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_en,
  output logic       wr_busy,
  output logic       irq
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              wren_q, sela_q, selb_q, done_q;
  logic              busy, commit, key_armed;
  logic [AW-1:0]     commit_addr;
  logic [BYTE_W-1:0] commit_data, arr_rdata;

  logic wr_any, ctrl_wr, data_wr, ptr_wr, sel_clear, start_wr, rd_go;

  assign wr_any    = bus_valid && bus_write;
  assign ctrl_wr   = wr_any && (bus_addr == OFS_CTRL);
  assign data_wr   = wr_any && (bus_addr == OFS_DATA);
  assign ptr_wr    = wr_any && (bus_addr == OFS_PTR);
  assign sel_clear = !bus_wdata[B_SELA] && !bus_wdata[B_SELB];
  assign start_wr  = ctrl_wr && bus_wdata[B_WR] && wren_q && key_armed
                     && sel_clear && !busy;
  assign rd_go     = ctrl_wr && bus_wdata[B_RD] && sel_clear && !busy && !start_wr;

  nvm_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_any), .wr_ofs(bus_addr),
    .wr_val(bus_wdata), .armed(key_armed)
  );

  nvm_write_timer #(.WR_CYCLES(WR_CYCLES), .AW(AW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_wr), .start_addr(addr_q),
    .start_data(data_q), .busy(busy), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  nvm_byte_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(commit_addr),
    .wdata(commit_data), .raddr(addr_q), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wren_q <= 1'b0;
      sela_q <= 1'b0;
      selb_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ptr_wr) addr_q <= bus_wdata[AW-1:0];
      if (rd_go)        data_q <= arr_rdata;
      else if (data_wr) data_q <= bus_wdata;
      if (ctrl_wr) begin
        wren_q <= bus_wdata[B_WEN];
        sela_q <= bus_wdata[B_SELA];
        selb_q <= bus_wdata[B_SELB];
      end
      if (commit)                              done_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[B_DONE])  done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_PTR:  bus_rdata = BYTE_W'(addr_q);
      OFS_DATA: bus_rdata = data_q;
      OFS_CTRL: bus_rdata = {2'b00, done_q, selb_q, sela_q, wren_q, busy, 1'b0};
      default:  bus_rdata = '0;
    endcase
  end

  assign wr_busy = busy;
  assign irq     = done_q && irq_en;
endmodule

// File: rtl/nvm_data_ctrl_chk.sv
module nvm_data_ctrl_chk #(
  parameter int unsigned WR_CYCLES = 64
)(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_write,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       irq_en,
  input logic       irq,
  input logic       busy,
  input logic       done,
  input logic       wren,
  input logic [7:0] data_q,
  input logic       key_armed
);
  localparam int unsigned NW = $clog2(WR_CYCLES + 2) + 1;
  logic [NW-1:0] busy_len;
  logic ctrl_wr;

  assign ctrl_wr = bus_valid && bus_write && (bus_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_start_keyed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key_armed && ctrl_wr && bus_wdata[1]));
  assert_start_needs_wren_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wren));
  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == NW'(WR_CYCLES)));
  assert_done_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  assert_wren_sw_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(wren));
  assert_read_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> $stable(data_q));
  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && done));
endmodule

bind nvm_data_ctrl nvm_data_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_en(irq_en), .irq(irq),
  .busy(busy), .done(done_q), .wren(wren_q), .data_q(data_q),
  .key_armed(key_armed)
);

// File: tb/test_nvm_data_ctrl.sv
module test_nvm_data_ctrl;
  localparam int DEPTH = 64;
  localparam int WR    = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, irq_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic wr_busy, irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  nvm_data_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WR)) i_nvm_data_ctrl (.*);

  // behavioural reference model
  int m_mem [DEPTH];
  int m_ptr, m_data, m_wen, m_sa, m_sb, m_done, m_busy, m_left, m_key, m_wa, m_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 255;
      m_ptr = 0; m_data = 0; m_wen = 0; m_sa = 0; m_sb = 0; m_done = 0;
      m_busy = 0; m_left = 0; m_key = 0; m_wa = 0; m_wd = 0;
    end else begin
      int ob, ok, ow, fin, d, isctrl, go;
      ob = m_busy; ok = m_key; ow = m_wen; d = bus_wdata;
      fin = 0;
      if (ob) begin
        if (m_left == 0) begin m_mem[m_wa] = m_wd; m_busy = 0; fin = 1; end
        else m_left--;
      end
      isctrl = bus_valid && bus_write && bus_addr == 2;
      go = 0;
      if (bus_valid && bus_write) begin
        if (bus_addr == 3) m_key = (d == 'h55) ? 1 : ((d == 'hAA && ok == 1) ? 2 : 0);
        else m_key = 0;
        if (bus_addr == 0) m_ptr = d % DEPTH;
        if (bus_addr == 1) m_data = d;
      end
      if (isctrl) begin
        if (d[1] && ow && ok == 2 && !d[3] && !d[4] && !ob) begin
          go = 1; m_busy = 1; m_left = WR - 1; m_wa = m_ptr; m_wd = m_data;
        end
        if (d[0] && !d[3] && !d[4] && !ob && !go) m_data = m_mem[m_ptr];
        m_wen = d[2]; m_sa = d[3]; m_sb = d[4];
      end
      if (fin) m_done = 1;
      else if (isctrl && !d[5]) m_done = 0;
    end
  end

  function automatic int exp_reg(input logic [1:0] a);
    case (a)
      2'd0: return m_ptr;
      2'd1: return m_data;
      2'd2: return (m_done << 5) | (m_sb << 4) | (m_sa << 3) | (m_wen << 2) | (m_busy << 1);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R2/R4/R9 model comparison on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2/R4 model rdata", bus_rdata, exp_reg(bus_addr));
      check("R12 model irq", irq, m_done & irq_en);
      check("R7 model busy", wr_busy, m_busy);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_check(input logic [1:0] a, input int exp, input string tag);
    bus_addr = a; #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 2'd2; #0.5;
    while (bus_rdata[1] && n < 1000) begin
      n++;
      @(negedge clk); #1; bus_addr = 2'd2; #0.5;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    rd_check(2'd0, 0, "R1 ptr"); rd_check(2'd1, 0, "R1 data");
    rd_check(2'd2, 0, "R1 ctrl"); check("R1 irq", irq, 0);
    wr(2'd0, 8'd5); wr(2'd2, 8'h01);
    rd_check(2'd1, 8'hFF, "R1 erased cell / R2 read");
    rd_check(2'd2, 0, "R2 read bit reads 0");
    // first store: 0x3C to cell 5, disturbed while running
    wr(2'd1, 8'h3C); wr(2'd2, 8'h04);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd_check(2'd2, 8'h06, "R5 store started");
    wr(2'd2, 8'h00);                 // clear permission mid-store
    wr(2'd0, 8'd9); wr(2'd1, 8'h77);
    wr(2'd2, 8'h01);                 // read during busy
    rd_check(2'd1, 8'h77, "R11 read ignored while busy");
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd_check(2'd2, 8'h06, "R11 store request during busy has no restart");
    wait_idle(n);
    check("R8 store not aborted, finished", n < 1000, 1);
    rd_check(2'd2, 8'h24, "R9 done set, R10 permission as software left it");
    wr(2'd0, 8'd5); wr(2'd2, 8'h21);
    rd_check(2'd1, 8'h3C, "R8 captured data stored at captured ptr");
    wr(2'd0, 8'd9); wr(2'd2, 8'h21);
    rd_check(2'd1, 8'hFF, "R8 rewritten ptr untouched");
    // R12 irq gating
    irq_en = 1; #0.5; check("R12 irq on", irq, 1);
    wr(2'd2, 8'h00); #0.5; check("R9 flag cleared / R12 irq off", irq, 0);
    wr(2'd2, 8'h20); rd_check(2'd2, 8'h00, "R9 software cannot set flag");
    // R6: permission set in the same write
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd_check(2'd2, 8'h04, "R6 no start without prior permission");
    // R5 deviations
    wr(2'd3, 8'h55); wr(2'd0, 8'd7); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    rd_check(2'd2, 8'h04, "R5 interleaved write breaks key");
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55); wr(2'd2, 8'h06);
    rd_check(2'd2, 8'h04, "R5 wrong key order");
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h0E);
    rd_check(2'd2, 8'h0C, "R5 select bit blocks store");
    // second store, measured length; R10 permission kept
    wr(2'd2, 8'h04); wr(2'd1, 8'hA5);
    wr(2'd3, 8'h55); bus_addr = 2'd2; #0.5;
    wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    wait_idle(n);
    check("R7 busy length", n, WR);
    rd_check(2'd2, 8'h24, "R10 permission kept after store");
    wr(2'd2, 8'h05);
    rd_check(2'd1, 8'hA5, "R7 cell written");
    // R13 no second store without new key
    wr(2'd1, 8'h11); wr(2'd2, 8'h06);
    rd_check(2'd2, 8'h04, "R13 fresh key needed");
    // R3 select blocks read; R4 hold
    wr(2'd1, 8'h42); wr(2'd2, 8'h0D);
    rd_check(2'd1, 8'h42, "R3 select blocks read");
    wr(2'd2, 8'h14);
    rd_check(2'd1, 8'h42, "R4 data held");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule